// File: doc/BRIEF.md
# Two-Processor Channel Flag Mailbox

This block lets two processors signal each other over a configurable number of channels, up to sixteen. Every channel carries one "occupied" flag per processor. A processor marks a channel as in use by setting its own flag; the other processor consumes the notification and frees the channel by clearing that flag. No payload is stored. Only the flag handshake and the interrupts derived from it live here.

Each processor owns a register group made of an interrupt-enable word, a per-channel mask word, a write-only set/clear word and a read-only flag status word. Two shared read-only words report the number of implemented channels and the revision. Each processor has its own single-cycle register port, and either port may reach any address. Writes take effect at the clock edge that samples them. Read data is registered. Each processor gets a level receive interrupt, raised by the peer's unmasked flags, and a level transmit interrupt, raised by its own unmasked free channels. Both interrupts are registered.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset all flags are clear, both enable words read 0, every implemented mask bit reads 1, and all four interrupts are low.
- R2: The enable word (group offset 0x0, group 0 at 0x00 and group 1 at 0x10) stores only bit 0 (receive enable) and bit 16 (transmit enable). All other bits read 0.
- R3: The mask word (group offset 0x4) keeps receive masks in bits 0..N-1 and transmit masks in bits 16..16+N-1. A set bit removes that channel from the interrupt.
- R4: On the set/clear word (group offset 0x8) of group g, a 1 in bit 16+n sets processor g's flag n and a 1 in bit n clears the other processor's flag n. Zero bits change nothing, and the word reads 0.
- R5: The status word (group offset 0xC) of group g returns processor g's flags in bits 0..N-1.
- R6: irq_rx[g] is high exactly when the previous cycle had receive enable g set and some channel n with the other processor's flag set and receive mask bit n of group g clear.
- R7: irq_tx[g] is high exactly when the previous cycle had transmit enable g set and some channel n with processor g's flag clear and transmit mask bit n of group g clear.
- R8: Address 0x3F0 reads the channel count N in bits 7:0. Address 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0. Writes to either address are ignored.
- R9: Bits that belong to channels at or above N are ignored on write and read as 0 in the mask and status words.
- R10: Writes to unmapped or unaligned addresses change no state, and reads of them return 0.
- R11: If one edge both sets and clears the same flag, the flag ends up set.
- R12: rsp_rdata of a port shows the addressed word, as it was before that edge, one edge after the read request is sampled. It reads 0 after any edge that sampled no read on that port.
- R13: If both ports write the same enable or mask word at the same edge, port 0's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-port access request |
| req_write | input | 2 | Per-port write (1) or read (0) |
| req_addr | input | 2*ADDR_W | Per-port byte address, port p at [p*ADDR_W +: ADDR_W] |
| req_wdata | input | 64 | Per-port write data, port p at [p*32 +: 32] |
| rsp_rdata | output | 64 | Per-port registered read data |
| irq_rx | output | 2 | Per-processor receive interrupt |
| irq_tx | output | 2 | Per-processor transmit interrupt |

## Verification
A write sampled at edge k updates flags, enables and masks at edge k. The interrupts that follow from that state become visible one edge later, at k+1, and read data for a request sampled at edge k is visible right after k. The bench drives on the falling edge. Before each rising edge it computes the expected read word and the expected interrupts from its model state, which matches the design state at that moment. It then updates the model and compares on the next falling edge, so each result is checked in the cycle it is due and never earlier.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int N_PROC   = 2;
  localparam int DW       = 32;
  localparam int TX_SHIFT = 16;
  localparam int MAX_CH   = 16;

  localparam logic [9:0] OFS_HWCFG = 10'h3F0;
  localparam logic [9:0] OFS_VER   = 10'h3F4;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_MASK,
    RK_SETCLR,
    RK_STATUS,
    RK_HWCFG,
    RK_VER
  } reg_kind_e;
endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic              grp
);
  always_comb begin
    kind = RK_NONE;
    grp  = addr[4];
    if (addr[ADDR_W-1:5] == '0 && addr[1:0] == 2'b00) begin
      case (addr[3:2])
        2'd0:    kind = RK_CTRL;
        2'd1:    kind = RK_MASK;
        2'd2:    kind = RK_SETCLR;
        default: kind = RK_STATUS;
      endcase
    end else if (addr == ADDR_W'(OFS_HWCFG)) begin
      kind = RK_HWCFG;
    end else if (addr == ADDR_W'(OFS_VER)) begin
      kind = RK_VER;
    end
  end
endmodule

// File: rtl/mbx_cfg_group.sv
module mbx_cfg_group
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PROC-1:0]          wr_ctrl,
  input  logic [N_PROC-1:0]          wr_mask,
  input  logic [N_PROC-1:0][DW-1:0]  wdata,
  output logic                       rx_en,
  output logic                       tx_en,
  output logic [NUM_CH-1:0]          mask_rx,
  output logic [NUM_CH-1:0]          mask_tx
);
  // Descending port order: the lowest port's write is applied last and wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      mask_rx <= '1;
      mask_tx <= '1;
    end else begin
      for (int p = N_PROC - 1; p >= 0; p--) begin
        if (wr_ctrl[p]) begin
          rx_en <= wdata[p][0];
          tx_en <= wdata[p][TX_SHIFT];
        end
        if (wr_mask[p]) begin
          mask_rx <= wdata[p][NUM_CH-1:0];
          mask_tx <= wdata[p][TX_SHIFT +: NUM_CH];
        end
      end
    end
  end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_PROC-1:0][NUM_CH-1:0] set_req,
  input  logic [N_PROC-1:0][NUM_CH-1:0] clr_req,
  output logic [N_PROC-1:0][NUM_CH-1:0] flags
);
  for (genvar g = 0; g < N_PROC; g++) begin : g_owner
    always_ff @(posedge clk) begin
      if (rst) flags[g] <= '0;
      else     flags[g] <= (flags[g] & ~clr_req[g]) | set_req[g];
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic [NUM_CH-1:0] mask_rx,
  input  logic [NUM_CH-1:0] mask_tx,
  input  logic [NUM_CH-1:0] own_flags,
  input  logic [NUM_CH-1:0] peer_flags,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic rx_hit, tx_hit;

  always_comb begin
    rx_hit = |(peer_flags & ~mask_rx);
    tx_hit = |(~own_flags & ~mask_tx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
    end else begin
      irq_rx <= rx_en & rx_hit;
      irq_tx <= tx_en & tx_hit;
    end
  end
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl
  import mbx_pkg::*;
#(
  parameter int          NUM_CH    = 12,
  parameter int          ADDR_W    = 10,
  parameter logic [3:0]  REV_MAJOR = 4'd1,
  parameter logic [3:0]  REV_MINOR = 4'd0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_PROC-1:0]        req_valid,
  input  logic [N_PROC-1:0]        req_write,
  input  logic [N_PROC*ADDR_W-1:0] req_addr,
  input  logic [N_PROC*DW-1:0]     req_wdata,
  output logic [N_PROC*DW-1:0]     rsp_rdata,
  output logic [N_PROC-1:0]        irq_rx,
  output logic [N_PROC-1:0]        irq_tx
);
  localparam int CNT_W = 8;

  reg_kind_e                      kind   [N_PROC];
  logic [N_PROC-1:0]              grp;
  logic [N_PROC-1:0][DW-1:0]      wdata;
  logic [N_PROC-1:0][N_PROC-1:0]  wr_ctrl_g;   // [group][port]
  logic [N_PROC-1:0][N_PROC-1:0]  wr_mask_g;
  logic [N_PROC-1:0][NUM_CH-1:0]  set_req;
  logic [N_PROC-1:0][NUM_CH-1:0]  clr_req;
  logic [N_PROC-1:0][NUM_CH-1:0]  flag_q;
  logic [N_PROC-1:0]              rx_en_q, tx_en_q;
  logic [N_PROC-1:0][NUM_CH-1:0]  mask_rx_q, mask_tx_q;
  logic [N_PROC-1:0][DW-1:0]      rd_word;
  logic [N_PROC-1:0][DW-1:0]      rdata_q;

  for (genvar p = 0; p < N_PROC; p++) begin : g_port
    assign wdata[p] = req_wdata[p*DW +: DW];
    mbx_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (req_addr[p*ADDR_W +: ADDR_W]),
      .kind (kind[p]),
      .grp  (grp[p])
    );
  end

  // Write strobes per group and flag requests per owner.
  always_comb begin
    wr_ctrl_g = '0;
    wr_mask_g = '0;
    set_req   = '0;
    clr_req   = '0;
    for (int p = 0; p < N_PROC; p++) begin
      if (req_valid[p] && req_write[p]) begin
        for (int g = 0; g < N_PROC; g++) begin
          if (grp[p] == 1'(g)) begin
            if (kind[p] == RK_CTRL) wr_ctrl_g[g][p] = 1'b1;
            if (kind[p] == RK_MASK) wr_mask_g[g][p] = 1'b1;
            if (kind[p] == RK_SETCLR) begin
              set_req[g]     = set_req[g] | wdata[p][TX_SHIFT +: NUM_CH];
              clr_req[1 - g] = clr_req[1 - g] | wdata[p][NUM_CH-1:0];
            end
          end
        end
      end
    end
  end

  for (genvar g = 0; g < N_PROC; g++) begin : g_grp
    mbx_cfg_group #(.NUM_CH(NUM_CH)) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .wr_ctrl (wr_ctrl_g[g]),
      .wr_mask (wr_mask_g[g]),
      .wdata   (wdata),
      .rx_en   (rx_en_q[g]),
      .tx_en   (tx_en_q[g]),
      .mask_rx (mask_rx_q[g]),
      .mask_tx (mask_tx_q[g])
    );

    mbx_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
      .clk        (clk),
      .rst        (rst),
      .rx_en      (rx_en_q[g]),
      .tx_en      (tx_en_q[g]),
      .mask_rx    (mask_rx_q[g]),
      .mask_tx    (mask_tx_q[g]),
      .own_flags  (flag_q[g]),
      .peer_flags (flag_q[1 - g]),
      .irq_rx     (irq_rx[g]),
      .irq_tx     (irq_tx[g])
    );
  end

  mbx_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_req (set_req),
    .clr_req (clr_req),
    .flags   (flag_q)
  );

  // Read multiplexer, one per port.
  always_comb begin
    for (int p = 0; p < N_PROC; p++) begin
      rd_word[p] = '0;
      case (kind[p])
        RK_CTRL: begin
          rd_word[p][0]        = rx_en_q[grp[p]];
          rd_word[p][TX_SHIFT] = tx_en_q[grp[p]];
        end
        RK_MASK: begin
          rd_word[p][NUM_CH-1:0]          = mask_rx_q[grp[p]];
          rd_word[p][TX_SHIFT +: NUM_CH]  = mask_tx_q[grp[p]];
        end
        RK_STATUS: rd_word[p][NUM_CH-1:0] = flag_q[grp[p]];
        RK_HWCFG:  rd_word[p][CNT_W-1:0]  = CNT_W'(NUM_CH);
        RK_VER:    rd_word[p][7:0]        = {REV_MAJOR, REV_MINOR};
        default:   rd_word[p] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < N_PROC; p++) begin
      if (rst)                                  rdata_q[p] <= '0;
      else if (req_valid[p] && !req_write[p])   rdata_q[p] <= rd_word[p];
      else                                      rdata_q[p] <= '0;
    end
  end

  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/mbx_flag_ctrl_chk.sv
module mbx_flag_ctrl_chk
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input logic                          clk,
  input logic                          rst,
  input logic [N_PROC-1:0]             irq_rx,
  input logic [N_PROC-1:0]             irq_tx,
  input logic [N_PROC-1:0]             rx_en,
  input logic [N_PROC-1:0]             tx_en,
  input logic [N_PROC-1:0][NUM_CH-1:0] mask_rx,
  input logic [N_PROC-1:0][NUM_CH-1:0] mask_tx,
  input logic [N_PROC-1:0][NUM_CH-1:0] flags,
  input logic [N_PROC-1:0][NUM_CH-1:0] set_req,
  input logic [N_PROC-1:0][NUM_CH-1:0] clr_req
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_rx == '0 && irq_tx == '0 && flags == '0));

  for (genvar g = 0; g < N_PROC; g++) begin : g_chk
    p_rx_cause_r6: assert property (@(posedge clk) disable iff (rst)
      irq_rx[g] |-> $past(rx_en[g] && |(flags[1-g] & ~mask_rx[g])));
    p_rx_fire_r6: assert property (@(posedge clk) disable iff (rst)
      $past(rx_en[g] && |(flags[1-g] & ~mask_rx[g])) |-> irq_rx[g]);
    p_tx_cause_r7: assert property (@(posedge clk) disable iff (rst)
      irq_tx[g] |-> $past(tx_en[g] && |(~flags[g] & ~mask_tx[g])));
    p_tx_fire_r7: assert property (@(posedge clk) disable iff (rst)
      $past(tx_en[g] && |(~flags[g] & ~mask_tx[g])) |-> irq_tx[g]);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
      (flags[g] & $past(set_req[g])) == $past(set_req[g]));
    p_clear_takes_r4: assert property (@(posedge clk) disable iff (rst)
      (flags[g] & $past(clr_req[g] & ~set_req[g])) == '0);
  end
endmodule

bind mbx_flag_ctrl mbx_flag_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_rx  (irq_rx),
  .irq_tx  (irq_tx),
  .rx_en   (rx_en_q),
  .tx_en   (tx_en_q),
  .mask_rx (mask_rx_q),
  .mask_tx (mask_tx_q),
  .flags   (flag_q),
  .set_req (set_req),
  .clr_req (clr_req)
);

// File: tb/sim_mbx_flag_ctrl.sv
`timescale 1ns/1ps
module sim_mbx_flag_ctrl;
  localparam int NCH = 12;
  localparam int AW  = 10;
  localparam logic [3:0] VMAJ = 4'd1;
  localparam logic [3:0] VMIN = 4'd0;
  localparam logic [15:0] CHM = 16'((32'd1 << NCH) - 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  req_valid = '0;
  logic [1:0]  req_write = '0;
  logic [2*AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic [1:0]  irq_rx, irq_tx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  bit          m_rx[2], m_tx[2];
  logic [15:0] m_mrx[2], m_mtx[2], m_fl[2];

  always #5 clk = ~clk;

  mbx_flag_ctrl #(.NUM_CH(NCH), .ADDR_W(AW), .REV_MAJOR(VMAJ), .REV_MINOR(VMIN)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [9:0] a);
    logic [31:0] w = '0;
    int g = a[4];
    if (a[9:5] == 0 && a[1:0] == 0) begin
      case (a[3:2])
        2'd0: begin w[0] = m_rx[g]; w[16] = m_tx[g]; end
        2'd1: w = {m_mtx[g], m_mrx[g]};
        2'd2: w = '0;
        default: w = {16'h0, m_fl[g]};
      endcase
    end else if (a == 10'h3F0) w = NCH;
    else if (a == 10'h3F4) w = {24'h0, VMAJ, VMIN};
    return w;
  endfunction

  function automatic string tag_of(input logic [9:0] a);
    if (a[9:5] == 0 && a[1:0] == 0) begin
      case (a[3:2])
        2'd0: return "R2";
        2'd1: return "R3";
        2'd2: return "R4";
        default: return "R5";
      endcase
    end
    if (a == 10'h3F0 || a == 10'h3F4) return "R8";
    return "R10";
  endfunction

  function automatic bit m_irq_rx(input int g);
    return m_rx[g] && ((m_fl[1-g] & ~m_mrx[g] & CHM) != 0);
  endfunction
  function automatic bit m_irq_tx(input int g);
    return m_tx[g] && ((~m_fl[g] & ~m_mtx[g] & CHM) != 0);
  endfunction

  task automatic m_reset();
    for (int g = 0; g < 2; g++) begin
      m_rx[g] = 0; m_tx[g] = 0; m_mrx[g] = CHM; m_mtx[g] = CHM; m_fl[g] = '0;
    end
  endtask

  task automatic m_update(input logic [1:0] v, input logic [1:0] w,
                          input logic [9:0] a[2], input logic [31:0] d[2]);
    logic [15:0] st[2], cl[2];
    st[0] = 0; st[1] = 0; cl[0] = 0; cl[1] = 0;
    for (int p = 1; p >= 0; p--) begin
      if (v[p] && w[p] && a[p][9:5] == 0 && a[p][1:0] == 0) begin
        int g = a[p][4];
        case (a[p][3:2])
          2'd0: begin m_rx[g] = d[p][0]; m_tx[g] = d[p][16]; end
          2'd1: begin m_mrx[g] = d[p][15:0] & CHM; m_mtx[g] = d[p][31:16] & CHM; end
          2'd2: begin st[g] |= d[p][31:16] & CHM; cl[1-g] |= d[p][15:0] & CHM; end
          default: ;
        endcase
      end
    end
    for (int g = 0; g < 2; g++) m_fl[g] = (m_fl[g] & ~cl[g]) | st[g];
  endtask

  // One access cycle on both ports; checks reads (R12) and interrupts.
  task automatic step(input logic [1:0] v, input logic [1:0] w,
                      input logic [9:0] a0, input logic [31:0] d0,
                      input logic [9:0] a1, input logic [31:0] d1);
    logic [9:0]  a[2];
    logic [31:0] d[2], er[2];
    bit erx[2], etx[2];
    a[0] = a0; a[1] = a1; d[0] = d0; d[1] = d1;
    req_valid = v; req_write = w;
    req_addr  = {a1, a0};
    req_wdata = {d1, d0};
    for (int p = 0; p < 2; p++) begin
      er[p]  = (v[p] && !w[p]) ? m_read(a[p]) : 32'h0;
      erx[p] = m_irq_rx(p);
      etx[p] = m_irq_tx(p);
    end
    @(posedge clk);
    m_update(v, w, a, d);
    @(negedge clk);
    req_valid = '0;
    for (int p = 0; p < 2; p++) begin
      if (v[p] && !w[p]) chk({tag_of(a[p]), " R12 read"}, rsp_rdata[p*32 +: 32], er[p]);
      else               chk("R12 idle read", rsp_rdata[p*32 +: 32], 32'h0);
      chk("R6 irq_rx", 32'(irq_rx[p]), 32'(erx[p]));
      chk("R7 irq_tx", 32'(irq_tx[p]), 32'(etx[p]));
    end
  endtask

  task automatic wr(input int p, input logic [9:0] a, input logic [31:0] d);
    if (p == 0) step(2'b01, 2'b01, a, d, 10'h0, 32'h0);
    else        step(2'b10, 2'b10, 10'h0, 32'h0, a, d);
  endtask

  task automatic rd(input int p, input logic [9:0] a);
    if (p == 0) step(2'b01, 2'b00, a, 32'h0, 10'h0, 32'h0);
    else        step(2'b10, 2'b00, 10'h0, 32'h0, a, 32'h0);
  endtask

  task automatic idle();
    step(2'b00, 2'b00, 10'h0, 32'h0, 10'h0, 32'h0);
  endtask

  function automatic logic [9:0] pick_addr();
    int k = $urandom % 11;
    if (k < 8) return {5'd0, k[2], k[1:0], 2'b00};
    if (k == 8) return 10'h3F0;
    if (k == 9) return 10'h3F4;
    return 10'($urandom);
  endfunction

  function automatic logic [31:0] pick_data();
    int k = $urandom % 4;
    if (k == 0) return 32'h0;
    if (k == 1) return 32'h1 << ($urandom % 32);
    return $urandom;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_rx", 32'(irq_rx), 32'h0);
    chk("R1 irq_tx", 32'(irq_tx), 32'h0);
    rd(0, 10'h04); chk("R1 mask g0", rsp_rdata[31:0], {CHM, CHM});
    rd(1, 10'h10); chk("R1 ctrl g1", rsp_rdata[63:32], 32'h0);
    rd(0, 10'h1C); chk("R1 status g1", rsp_rdata[31:0], 32'h0);
    // R8 config and revision, writes ignored
    wr(0, 10'h3F0, 32'hFFFF_FFFF);
    rd(1, 10'h3F0); chk("R8 hwcfg", rsp_rdata[63:32], NCH);
    rd(0, 10'h3F4); chk("R8 version", rsp_rdata[31:0], {24'h0, VMAJ, VMIN});
    // R2 enable word keeps bits 0 and 16 only
    wr(0, 10'h00, 32'hFFFF_FFFF);
    rd(0, 10'h00); chk("R2 ctrl", rsp_rdata[31:0], 32'h0001_0001);
    // R3 + R9: mask write, unimplemented bits read 0
    wr(1, 10'h04, 32'hFFFF_FFFF);
    rd(1, 10'h04); chk("R9 mask", rsp_rdata[63:32], {CHM, CHM});
    wr(0, 10'h04, 32'h0000_0000);
    rd(0, 10'h04); chk("R3 mask", rsp_rdata[31:0], 32'h0);
    // R7: tx enabled, unmasked, all flags free -> irq_tx[0]
    idle(); chk("R7 tx free", 32'(irq_tx[0]), 32'h1);
    // R5: processor 0 sets its channel 3
    wr(0, 10'h08, 32'h0008_0000);
    rd(1, 10'h0C); chk("R5 status g0", rsp_rdata[63:32], 32'h0000_0008);
    rd(0, 10'h1C); chk("R5 status g1", rsp_rdata[31:0], 32'h0);
    rd(0, 10'h08); chk("R4 setclr reads 0", rsp_rdata[31:0], 32'h0);
    // R6: group 1 receive enabled and unmasked sees peer flag 3
    wr(1, 10'h14, 32'hFFFF_0000);
    wr(1, 10'h10, 32'h0000_0001);
    idle(); chk("R6 rx peer", 32'(irq_rx[1]), 32'h1);
    // R4: zero write no effect, then clear by peer
    wr(1, 10'h18, 32'h0);
    rd(0, 10'h0C); chk("R4 zero write", rsp_rdata[31:0], 32'h0000_0008);
    wr(1, 10'h18, 32'h0000_0008);
    rd(0, 10'h0C); chk("R4 peer clear", rsp_rdata[31:0], 32'h0);
    idle(); chk("R6 rx drops", 32'(irq_rx[1]), 32'h0);
    // R9: unimplemented channel set ignored
    wr(0, 10'h08, 32'h8000_0000);
    rd(0, 10'h0C); chk("R9 status", rsp_rdata[31:0], 32'h0);
    // R10: unmapped write and read
    wr(0, 10'h104, 32'hFFFF_FFFF);
    wr(1, 10'h006, 32'hFFFF_FFFF);
    rd(0, 10'h104); chk("R10 unmapped read", rsp_rdata[31:0], 32'h0);
    rd(1, 10'h04); chk("R10 mask kept", rsp_rdata[63:32], 32'h0);
    // R11: set and clear of flag0[5] on the same edge
    step(2'b11, 2'b11, 10'h08, 32'h0020_0000, 10'h18, 32'h0000_0020);
    rd(1, 10'h0C); chk("R11 set wins", rsp_rdata[63:32], 32'h0000_0020);
    // R13: both ports write the same enable word
    step(2'b11, 2'b11, 10'h10, 32'h0001_0000, 10'h10, 32'h0000_0001);
    rd(1, 10'h10); chk("R13 port0 wins", rsp_rdata[63:32], 32'h0001_0000);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] v = 2'($urandom);
      logic [1:0] w = 2'($urandom);
      step(v, w, pick_addr(), pick_data(), pick_addr(), pick_data());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule